// File: doc/BRIEF.md
# Debug-Session Instruction Translation Bypass

This block holds a 32-bit debug control register and uses it to override the instruction-side address translation result during a debug session. The register is read and written through a simple strobe port. When a debug session is active, external debug access is enabled and the register's translation-disable bit is set, the block replaces the TLB result for instruction fetches. The physical address becomes the fetch address. The page attributes come from register bits. Both execute permissions are forced on. TLB miss and TLB fault indications are suppressed.

In every other case the TLB lookup result passes through unchanged. An external access error input always reaches its output, in bypass as well as in normal translation. The register uses big-endian bit numbering. Bit 0 is the most significant bit, so big-endian bit n sits at vector index 31-n.

Top module: `ifetch_dbg_bypass`

## Requirements
- R1: The register clears to zero while `por_n` is low or `tst_rst_n` is low (asynchronous). It also clears on a clock edge where `tlr_state` is high, and this clear wins over a write in the same cycle.
- R2: A write stores only five bits. Big-endian bit 8 (index 23) is the translation-disable bit. Bits 11, 12, 13 and 15 (indices 20, 19, 18, 16) are the VLE, I, M and E attributes. Every other bit ignores writes and reads as zero, so writing 0xFFFF_FFFF reads back 0x009D_0000.
- R3: `reg_rdata` shows the register value in the same cycle `reg_rd` is high, and is zero when `reg_rd` is low.
- R4: `bypass` is high exactly when `dbg_en`, `dbg_session` and the disable bit are all high. With `dbg_en` low or `dbg_session` low, the register has no effect on the outputs.
- R5: In bypass, `ipa` equals `fetch_addr`.
- R6: In bypass, `iattr` = {VLE, I, M, E} taken from the register; in normal operation it equals `tlb_attr` in the same order.
- R7: In bypass, `sx_perm` and `ux_perm` are both 1.
- R8: In bypass, `itlb_miss` and `itlb_fault` are 0. `ext_err_out` follows `ext_err` in every mode.
- R9: Outside bypass, `ipa`, `iattr`, `sx_perm`, `ux_perm`, `itlb_miss` and `itlb_fault` equal the TLB inputs.
- R10: A register write takes effect on the outputs in the cycle right after the write edge, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tst_rst_n | input | 1 | Test reset, active low, asynchronous |
| tlr_state | input | 1 | Test-logic-reset state, synchronous clear |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data |
| dbg_session | input | 1 | Debug session active |
| dbg_en | input | 1 | External debug access enabled |
| fetch_addr | input | AW | Instruction fetch effective address |
| tlb_pa | input | AW | TLB physical address |
| tlb_attr | input | 4 | TLB attributes {VLE, I, M, E} |
| tlb_sx | input | 1 | TLB supervisor execute permission |
| tlb_ux | input | 1 | TLB user execute permission |
| tlb_miss | input | 1 | TLB miss |
| tlb_fault | input | 1 | TLB exception |
| ext_err | input | 1 | External access error |
| ipa | output | AW | Selected physical address |
| iattr | output | 4 | Selected attributes {VLE, I, M, E} |
| sx_perm | output | 1 | Selected supervisor execute permission |
| ux_perm | output | 1 | Selected user execute permission |
| itlb_miss | output | 1 | Miss after masking |
| itlb_fault | output | 1 | TLB exception after masking |
| ext_err_out | output | 1 | External error, unmasked |
| bypass | output | 1 | Translation bypass active |

## Verification
The assertions check the output selection on every cycle. In bypass they confirm the identity address, forced permissions and masked exceptions. Outside bypass they confirm that the TLB result passes through. They also check that reserved bits read as zero, that a write or a test-logic-reset clear shows up on the next read, and that the error output follows its input.

Some behaviour can only be shown by the bench's scenarios. These are the asynchronous clears from the two reset pins, a clear winning over a simultaneous write, and specific attribute bit patterns reaching their output positions. The bench also shows that one gating input alone, with the others held high, leaves the TLB result intact.

// File: rtl/ifetch_dbg_bypass_pkg.sv
package ifetch_dbg_bypass_pkg;
   localparam int REG_W = 32;

   // big-endian bit number -> vector index
   function automatic int be_idx(input int be_bit);
      return REG_W - 1 - be_bit;
   endfunction

   localparam int IDX_DIS = be_idx(8);
   localparam int IDX_VLE = be_idx(11);
   localparam int IDX_I   = be_idx(12);
   localparam int IDX_M   = be_idx(13);
   localparam int IDX_E   = be_idx(15);

   localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'(1) << IDX_DIS) | (REG_W'(1) << IDX_VLE) | (REG_W'(1) << IDX_I) |
      (REG_W'(1) << IDX_M)   | (REG_W'(1) << IDX_E);

   typedef struct packed {
      logic vle;
      logic i;
      logic m;
      logic e;
   } page_attr_t;

   typedef struct packed {
      logic       dis;
      page_attr_t attr;
   } dbg_ctl_t;
endpackage

// File: rtl/ifetch_dbg_ctl_reg.sv
module ifetch_dbg_ctl_reg
   import ifetch_dbg_bypass_pkg::*;
#(
   parameter bit RD_GATED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_clr,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             rd,
   output logic [REG_W-1:0] rdata,
   output dbg_ctl_t         ctl
);
   logic [REG_W-1:0] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        store_q <= '0;
      else if (sync_clr) store_q <= '0;
      else if (wr)       store_q <= wdata & WR_MASK;
   end

   assign ctl.dis      = store_q[IDX_DIS];
   assign ctl.attr.vle = store_q[IDX_VLE];
   assign ctl.attr.i   = store_q[IDX_I];
   assign ctl.attr.m   = store_q[IDX_M];
   assign ctl.attr.e   = store_q[IDX_E];

   generate
      if (RD_GATED) begin : g_rd_gated
         assign rdata = rd ? store_q : '0;
      end else begin : g_rd_open
         logic unused_rd;
         assign unused_rd = rd;
         assign rdata     = store_q;
      end
   endgenerate
endmodule

// File: rtl/ifetch_xlate_sel.sv
module ifetch_xlate_sel
   import ifetch_dbg_bypass_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          sel_bypass,
   input  page_attr_t    reg_attr,
   input  logic [AW-1:0] fetch_addr,
   input  logic [AW-1:0] tlb_pa,
   input  page_attr_t    tlb_attr,
   input  logic          tlb_sx,
   input  logic          tlb_ux,
   input  logic          tlb_miss,
   input  logic          tlb_fault,
   output logic [AW-1:0] ipa,
   output page_attr_t    iattr,
   output logic          sx_perm,
   output logic          ux_perm,
   output logic          itlb_miss,
   output logic          itlb_fault
);
   always_comb begin
      if (sel_bypass) begin
         ipa        = fetch_addr;
         iattr      = reg_attr;
         sx_perm    = 1'b1;
         ux_perm    = 1'b1;
         itlb_miss  = 1'b0;
         itlb_fault = 1'b0;
      end else begin
         ipa        = tlb_pa;
         iattr      = tlb_attr;
         sx_perm    = tlb_sx;
         ux_perm    = tlb_ux;
         itlb_miss  = tlb_miss;
         itlb_fault = tlb_fault;
      end
   end
endmodule

// File: rtl/ifetch_dbg_bypass.sv
module ifetch_dbg_bypass
   import ifetch_dbg_bypass_pkg::*;
#(
   parameter int AW       = 32,
   parameter bit RD_GATED = 1'b1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          tst_rst_n,
   input  logic          tlr_state,
   input  logic          reg_wr,
   input  logic [31:0]   reg_wdata,
   input  logic          reg_rd,
   output logic [31:0]   reg_rdata,
   input  logic          dbg_session,
   input  logic          dbg_en,
   input  logic [AW-1:0] fetch_addr,
   input  logic [AW-1:0] tlb_pa,
   input  logic [3:0]    tlb_attr,
   input  logic          tlb_sx,
   input  logic          tlb_ux,
   input  logic          tlb_miss,
   input  logic          tlb_fault,
   input  logic          ext_err,
   output logic [AW-1:0] ipa,
   output logic [3:0]    iattr,
   output logic          sx_perm,
   output logic          ux_perm,
   output logic          itlb_miss,
   output logic          itlb_fault,
   output logic          ext_err_out,
   output logic          bypass
);
   generate
      if (AW < 12 || AW > 64) begin : g_bad_aw
         $error("ifetch_dbg_bypass: AW must be within 12..64");
      end
   endgenerate

   logic       rst_n;
   dbg_ctl_t   ctl;
   page_attr_t sel_attr;

   assign rst_n = por_n & tst_rst_n;

   ifetch_dbg_ctl_reg #(.RD_GATED(RD_GATED)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_clr (tlr_state),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .rd       (reg_rd),
      .rdata    (reg_rdata),
      .ctl      (ctl)
   );

   assign bypass = dbg_en & dbg_session & ctl.dis;

   ifetch_xlate_sel #(.AW(AW)) u_sel (
      .sel_bypass (bypass),
      .reg_attr   (ctl.attr),
      .fetch_addr (fetch_addr),
      .tlb_pa     (tlb_pa),
      .tlb_attr   (page_attr_t'(tlb_attr)),
      .tlb_sx     (tlb_sx),
      .tlb_ux     (tlb_ux),
      .tlb_miss   (tlb_miss),
      .tlb_fault  (tlb_fault),
      .ipa        (ipa),
      .iattr      (sel_attr),
      .sx_perm    (sx_perm),
      .ux_perm    (ux_perm),
      .itlb_miss  (itlb_miss),
      .itlb_fault (itlb_fault)
   );

   assign iattr       = sel_attr;
   assign ext_err_out = ext_err;
endmodule

// File: rtl/ifetch_dbg_bypass_chk.sv
module ifetch_dbg_bypass_chk
   import ifetch_dbg_bypass_pkg::*;
#(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tlr_state,
   input logic          reg_wr,
   input logic [31:0]   reg_wdata,
   input logic          reg_rd,
   input logic [31:0]   reg_rdata,
   input logic          dbg_session,
   input logic          dbg_en,
   input logic [AW-1:0] fetch_addr,
   input logic [AW-1:0] tlb_pa,
   input logic [3:0]    tlb_attr,
   input logic          tlb_sx,
   input logic          tlb_ux,
   input logic          tlb_miss,
   input logic          tlb_fault,
   input logic          ext_err,
   input logic [AW-1:0] ipa,
   input logic [3:0]    iattr,
   input logic          sx_perm,
   input logic          ux_perm,
   input logic          itlb_miss,
   input logic          itlb_fault,
   input logic          ext_err_out,
   input logic          bypass
);
   assert_tlr_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tlr_state) && reg_rd) |-> reg_rdata == 32'h0);

   assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> (reg_rdata & ~WR_MASK) == 32'h0);

   assert_idle_rdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |-> reg_rdata == 32'h0);

   assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_en || !dbg_session) |-> !bypass);

   assert_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> ipa == fetch_addr);

   assert_perm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (sx_perm && ux_perm));

   assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (!itlb_miss && !itlb_fault));

   assert_exterr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_err_out == ext_err);

   assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bypass |-> (ipa == tlb_pa && iattr == tlb_attr && sx_perm == tlb_sx &&
                   ux_perm == tlb_ux && itlb_miss == tlb_miss && itlb_fault == tlb_fault));

   assert_write_seen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_wr && !tlr_state) && reg_rd) |-> reg_rdata == ($past(reg_wdata) & WR_MASK));
endmodule

bind ifetch_dbg_bypass ifetch_dbg_bypass_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_ifetch_dbg_bypass.sv
`timescale 1ns/1ps
module tb_ifetch_dbg_bypass;
   localparam int AW = 32;
   localparam logic [31:0] TLB_PA = 32'hDEAD_0000;

   logic          clk = 1'b0;
   logic          por_n = 1'b0, tst_rst_n = 1'b1, tlr_state = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0]   reg_wdata = '0, reg_rdata;
   logic          dbg_session = 1'b0, dbg_en = 1'b0;
   logic [AW-1:0] fetch_addr = 32'h0000_1234, tlb_pa = TLB_PA, ipa;
   logic [3:0]    tlb_attr = 4'b0000, iattr;
   logic          tlb_sx = 1'b0, tlb_ux = 1'b0, tlb_miss = 1'b1, tlb_fault = 1'b1, ext_err = 1'b0;
   logic          sx_perm, ux_perm, itlb_miss, itlb_fault, ext_err_out, bypass;

   int n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   ifetch_dbg_bypass #(.AW(AW)) dut (.*);

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [31:0] v);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_reg(output logic [31:0] v);
      reg_rd = 1'b1; #1; v = reg_rdata; reg_rd = 1'b0; #1;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd_reg(v);
      chk("R1", "reset value", v, 32'h0);
      chk("R9", "pass pa", ipa, TLB_PA);
      chk("R9", "pass miss/fault", {30'b0, itlb_miss, itlb_fault}, 32'h3);
      #1; chk("R3", "idle rdata", reg_rdata, 32'h0);
   endtask

   task automatic t_mask;
      logic [31:0] v;
      wr_reg(32'hFFFF_FFFF);
      rd_reg(v);
      chk("R2", "reserved masked", v, 32'h009D_0000);
      chk("R3", "idle rdata after write", reg_rdata, 32'h0);
   endtask

   task automatic t_bypass;
      dbg_en = 1'b1; dbg_session = 1'b1; ext_err = 1'b1; #1;
      chk("R4", "bypass on", {31'b0, bypass}, 32'h1);
      chk("R5", "identity pa", ipa, 32'h0000_1234);
      chk("R6", "reg attr all", {28'b0, iattr}, 32'hF);
      chk("R7", "perm forced", {30'b0, sx_perm, ux_perm}, 32'h3);
      chk("R8", "exceptions masked", {30'b0, itlb_miss, itlb_fault}, 32'h0);
      chk("R8", "ext err passes", {31'b0, ext_err_out}, 32'h1);
      ext_err = 1'b0;
   endtask

   task automatic t_gating;
      dbg_en = 1'b0; #1;
      chk("R4", "enable low no bypass", {31'b0, bypass}, 32'h0);
      chk("R9", "enable low pa", ipa, TLB_PA);
      dbg_en = 1'b1; dbg_session = 1'b0; tlb_attr = 4'b1010; tlb_sx = 1'b1; #1;
      chk("R4", "no session no bypass", {31'b0, bypass}, 32'h0);
      chk("R9", "pass attr", {28'b0, iattr}, 32'hA);
      chk("R9", "pass perm", {30'b0, sx_perm, ux_perm}, 32'h2);
      dbg_session = 1'b1; tlb_attr = 4'b0000; tlb_sx = 1'b0;
   endtask

   task automatic t_attr_pattern;
      // dis (idx23) + I (idx19) + E (idx16) -> {vle,i,m,e} = 0101
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h0089_0000;
      @(posedge clk); #1; reg_wr = 1'b0;
      chk("R10", "new attr next cycle", {28'b0, iattr}, 32'h5);
      chk("R6", "I and E only", {28'b0, iattr}, 32'h5);
      wr_reg(32'h0009_0000);
      chk("R10", "disable cleared", {31'b0, bypass}, 32'h0);
      chk("R9", "miss passes", {31'b0, itlb_miss}, 32'h1);
   endtask

   task automatic t_clears;
      logic [31:0] v;
      wr_reg(32'h0080_0000);
      @(negedge clk); tlr_state = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0080_0000;
      @(negedge clk); tlr_state = 1'b0; reg_wr = 1'b0;
      rd_reg(v);
      chk("R1", "tlr clear wins", v, 32'h0);
      wr_reg(32'h0080_0000);
      tst_rst_n = 1'b0; #1;
      rd_reg(v);
      chk("R1", "test reset clears", v, 32'h0);
      tst_rst_n = 1'b1;
      wr_reg(32'h0080_0000);
      por_n = 1'b0; #1;
      rd_reg(v);
      chk("R1", "power-on clears", v, 32'h0);
      por_n = 1'b1;
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            por_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_mask();
            t_bypass();
            t_gating();
            t_attr_pattern();
            t_clears();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule